// File: doc/BRIEF.md
# Write-Only Line Staging Queue with Burst Flush

This block gathers processor stores into small line-sized staging buffers and later pushes a complete line out to memory as one burst write. It holds two independent 32-byte queues, and address bit 5 of a store or a flush picks the queue. Because a line is never filled from memory, a program that overwrites a whole region pays no read traffic. With a write-back cache, the same program would first fetch data that it then throws away.

Memory is written only when a flush command arrives. The command carries the target address. Its line-aligned part becomes the base of an eight-beat, 32-bit incrementing burst, and the final beat is flagged. While one queue drains, the other keeps taking stores. A store to the draining queue, or any further flush command, is held off until the burst ends. Bytes that were not written since the previous flush still go out, and their values are unspecified.

Top module: `sq_burst_writer`

## Requirements
- R1: An accepted store writes only the bytes whose enable bit is set (enable bit b covers data bits 8b+7..8b) into word st_addr[4:2] of queue st_addr[5]. All other bytes of the line keep their values.
- R2: Every accepted flush produces exactly 8 accepted beats on the burst port. bw_last is high on the eighth beat only, and no further beat follows.
- R3: Beat i has address {fl_addr[31:5], 5'b0} + 4*i and carries word i of queue fl_addr[5]. Bits 4:0 of the flush address are ignored.
- R4: bw_valid rises only in the cycle after a flush command is accepted. Stores alone, however long they sit, never start a memory write.
- R5: While queue q drains, a store to queue q sees st_ready low and does not change that queue. A store to the other queue is accepted.
- R6: While bw_valid is high and bw_ready is low, bw_addr, bw_data and bw_last hold their values.
- R7: fl_ready is low while a burst is in progress. A store and a flush to the same idle queue, presented in the same cycle, are both accepted, and the burst carries the new store.
- R8: q_busy[q] is high from the cycle after the flush of queue q is accepted until the last beat is accepted, and at most one bit is set. flush_done is high for exactly the one cycle that follows acceptance of the last beat.
- R9: After reset, bw_valid, q_busy and flush_done are low, and st_ready and fl_ready are high.
- R10: A flush does not clear a queue. Flushing again with no new stores sends the same data again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted when high together with st_valid |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables |
| fl_valid | input | 1 | Flush command request |
| fl_ready | output | 1 | Flush command accepted when high together with fl_valid |
| fl_addr | input | 32 | Flush target address (line part used, bit 5 picks the queue) |
| bw_valid | output | 1 | Burst beat valid |
| bw_ready | input | 1 | Memory takes the beat |
| bw_addr | output | 32 | Beat address |
| bw_data | output | 32 | Beat data |
| bw_last | output | 1 | Final beat of the burst |
| q_busy | output | 2 | Per-queue draining status |
| flush_done | output | 1 | One-cycle pulse after the final beat |

## Verification
The assertions check the following on every cycle:
- the stall of stores aimed at a draining queue;
- the refusal of flush commands during a burst;
- the four-byte address step between accepted beats;
- the stability of a beat under backpressure;
- the eight-beat count ending on bw_last;
- the rule that a burst starts only after an accepted flush and that the done pulse follows the last beat.

Only the bench scenarios can show that the beat data carries the right bytes. This covers partial byte enables, a stalled store that must not land, a store that coincides with its flush, and a repeat flush with no new stores. Checking these needs a bench-side model of the line contents.

// File: rtl/sq_pkg.sv
package sq_pkg;
    localparam int unsigned SQ_ADDR_W     = 32;
    localparam int unsigned SQ_DATA_W     = 32;
    localparam int unsigned SQ_LINE_BYTES = 32;
    localparam int unsigned SQ_NUM_Q      = 2;
endpackage

// File: rtl/sq_line_store.sv
// One line of write-only staging storage with byte-lane write and word read.
module sq_line_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BEATS  = 8,
    localparam int unsigned IDX_W = $clog2(BEATS),
    localparam int unsigned BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [BEATS-1:0][DATA_W-1:0] words;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (wr_en) begin
            for (int b = 0; b < int'(BE_W); b++) begin
                if (wr_be[b]) begin
                    line_d.words[wr_idx][8*b +: 8] = wr_data[8*b +: 8];
                end
            end
        end
    end

    // Data storage carries no reset: unwritten bytes are unspecified.
    always_ff @(posedge clk) begin
        line_q <= line_d;
    end

    assign rd_data = line_q.words[rd_idx];
endmodule

// File: rtl/sq_burst_seq.sv
// Burst sequencer: one line per accepted flush, fixed beat count.
module sq_burst_seq #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned BEATS   = 8,
    parameter int unsigned QSEL_W  = 1,
    localparam int unsigned IDX_W   = $clog2(BEATS),
    localparam int unsigned STEP_SH = $clog2(DATA_W / 8),
    localparam int unsigned OFF_W   = IDX_W + STEP_SH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [QSEL_W-1:0] start_q,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              beat_ready,
    output logic              active,
    output logic [QSEL_W-1:0] cur_q,
    output logic [IDX_W-1:0]  beat_idx,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_last,
    output logic              done
);
    typedef struct packed {
        logic              active;
        logic [QSEL_W-1:0] q;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  idx;
        logic              done;
    } seq_t;

    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

    seq_t s_d, s_q;
    logic at_last;

    assign at_last = (s_q.idx == IDX_W'(BEATS - 1));

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.active) begin
            if (beat_ready) begin
                if (at_last) begin
                    s_d.active = 1'b0;
                    s_d.done   = 1'b1;
                    s_d.idx    = '0;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
        end else if (start) begin
            s_d.active = 1'b1;
            s_d.q      = start_q;
            s_d.base   = start_addr & LINE_MASK;
            s_d.idx    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active    = s_q.active;
    assign cur_q     = s_q.q;
    assign beat_idx  = s_q.idx;
    assign beat_addr = s_q.base + (ADDR_W'(s_q.idx) << STEP_SH);
    assign beat_last = s_q.active && at_last;
    assign done      = s_q.done;
endmodule

// File: rtl/sq_burst_writer.sv
// Write-only staging queues drained to memory by explicit flush bursts.
module sq_burst_writer
    import sq_pkg::*;
#(
    parameter int unsigned ADDR_W     = SQ_ADDR_W,
    parameter int unsigned DATA_W     = SQ_DATA_W,
    parameter int unsigned LINE_BYTES = SQ_LINE_BYTES,
    parameter int unsigned NUM_Q      = SQ_NUM_Q,
    localparam int unsigned BYTES_W   = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_valid,
    output logic               st_ready,
    input  logic [ADDR_W-1:0]  st_addr,
    input  logic [DATA_W-1:0]  st_data,
    input  logic [BYTES_W-1:0] st_be,
    input  logic               fl_valid,
    output logic               fl_ready,
    input  logic [ADDR_W-1:0]  fl_addr,
    output logic               bw_valid,
    input  logic               bw_ready,
    output logic [ADDR_W-1:0]  bw_addr,
    output logic [DATA_W-1:0]  bw_data,
    output logic               bw_last,
    output logic [NUM_Q-1:0]   q_busy,
    output logic               flush_done
);
    localparam int unsigned BEATS   = LINE_BYTES / BYTES_W;
    localparam int unsigned STEP_SH = $clog2(BYTES_W);
    localparam int unsigned IDX_W   = $clog2(BEATS);
    localparam int unsigned OFF_W   = $clog2(LINE_BYTES);
    localparam int unsigned QSEL_W  = $clog2(NUM_Q);

    logic [QSEL_W-1:0] st_q, fl_q, cur_q;
    logic [IDX_W-1:0]  st_idx, beat_idx;
    logic              active;
    logic              st_fire, fl_fire;
    logic [DATA_W-1:0] rd_words [NUM_Q];
    logic              st_addr_unused;

    assign st_q   = st_addr[OFF_W +: QSEL_W];
    assign st_idx = st_addr[STEP_SH +: IDX_W];
    assign fl_q   = fl_addr[OFF_W +: QSEL_W];
    assign st_addr_unused = ^{st_addr[ADDR_W-1:OFF_W+QSEL_W], st_addr[STEP_SH-1:0]};

    // A store waits only for its own queue; a flush waits for the engine.
    assign st_ready = !q_busy[st_q];
    assign fl_ready = !active;
    assign st_fire  = st_valid && st_ready;
    assign fl_fire  = fl_valid && fl_ready;

    sq_burst_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BEATS  (BEATS),
        .QSEL_W (QSEL_W)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fl_fire),
        .start_q    (fl_q),
        .start_addr (fl_addr),
        .beat_ready (bw_ready),
        .active     (active),
        .cur_q      (cur_q),
        .beat_idx   (beat_idx),
        .beat_addr  (bw_addr),
        .beat_last  (bw_last),
        .done       (flush_done)
    );

    for (genvar qi = 0; qi < NUM_Q; qi++) begin : g_queue
        logic wr_en;
        assign wr_en      = st_fire && (st_q == QSEL_W'(qi));
        assign q_busy[qi] = active && (cur_q == QSEL_W'(qi));

        sq_line_store #(
            .DATA_W (DATA_W),
            .BEATS  (BEATS)
        ) i_line (
            .clk     (clk),
            .wr_en   (wr_en),
            .wr_idx  (st_idx),
            .wr_data (st_data),
            .wr_be   (st_be),
            .rd_idx  (beat_idx),
            .rd_data (rd_words[qi])
        );
    end

    assign bw_valid = active;
    assign bw_data  = rd_words[cur_q];
endmodule

// File: rtl/sq_burst_writer_chk.sv
// Cycle-level property checker attached to the top module.
module sq_burst_writer_chk #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned NUM_Q      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic [ADDR_W-1:0] st_addr,
    input logic              fl_valid,
    input logic              fl_ready,
    input logic              bw_valid,
    input logic              bw_ready,
    input logic [ADDR_W-1:0] bw_addr,
    input logic [DATA_W-1:0] bw_data,
    input logic              bw_last,
    input logic [NUM_Q-1:0]  q_busy,
    input logic              flush_done
);
    localparam int unsigned BYTES_W = DATA_W / 8;
    localparam int unsigned BEATS   = LINE_BYTES / BYTES_W;
    localparam int unsigned CNT_W   = $clog2(BEATS) + 1;
    localparam int unsigned OFF_W   = $clog2(LINE_BYTES);
    localparam int unsigned QSEL_W  = $clog2(NUM_Q);

    logic [CNT_W-1:0] beat_cnt_q;
    logic [QSEL_W-1:0] st_q;
    logic st_addr_unused;

    assign st_q = st_addr[OFF_W +: QSEL_W];
    assign st_addr_unused = ^{st_addr[ADDR_W-1:OFF_W+QSEL_W], st_addr[OFF_W-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_cnt_q <= '0;
        end else if (bw_valid && bw_ready) begin
            beat_cnt_q <= bw_last ? '0 : beat_cnt_q + 1'b1;
        end
    end

    // R2
    a_r2_eight_beats: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_valid && bw_last) |-> (beat_cnt_q == CNT_W'(BEATS - 1)));

    // R3
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_valid && bw_ready && !bw_last) |=>
            (bw_valid && bw_addr == $past(bw_addr) + ADDR_W'(BYTES_W)));

    // R4
    a_r4_start_by_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bw_valid) |-> $past(fl_valid && fl_ready));

    // R5
    a_r5_store_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && q_busy[st_q]) |-> !st_ready);

    // R6
    a_r6_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_valid && !bw_ready) |=>
            (bw_valid && $stable(bw_addr) && $stable(bw_data) && $stable(bw_last)));

    // R7
    a_r7_flush_stall: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid |-> !fl_ready);

    // R8
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> ($past(bw_valid && bw_ready && bw_last) && !bw_valid));

    // R8
    a_r8_busy_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q_busy));
endmodule

bind sq_burst_writer sq_burst_writer_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LINE_BYTES (LINE_BYTES),
    .NUM_Q      (NUM_Q)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_ready   (st_ready),
    .st_addr    (st_addr),
    .fl_valid   (fl_valid),
    .fl_ready   (fl_ready),
    .bw_valid   (bw_valid),
    .bw_ready   (bw_ready),
    .bw_addr    (bw_addr),
    .bw_data    (bw_data),
    .bw_last    (bw_last),
    .q_busy     (q_busy),
    .flush_done (flush_done)
);

// File: tb/test_sq_burst_writer.sv
module test_sq_burst_writer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0, st_ready;
    logic [31:0] st_addr = '0, st_data = '0;
    logic [3:0]  st_be = '0;
    logic        fl_valid = 1'b0, fl_ready;
    logic [31:0] fl_addr = '0;
    logic        bw_valid, bw_ready = 1'b0, bw_last;
    logic [31:0] bw_addr, bw_data;
    logic [1:0]  q_busy;
    logic        flush_done;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] mdl [2][8];

    always #(CLK_PERIOD/2) clk = ~clk;

    sq_burst_writer i_sq_burst_writer (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be),
        .fl_valid(fl_valid), .fl_ready(fl_ready), .fl_addr(fl_addr),
        .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_addr(bw_addr),
        .bw_data(bw_data), .bw_last(bw_last),
        .q_busy(q_busy), .flush_done(flush_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        #1;
        while (!st_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        st_valid = 1'b0;
        for (int b = 0; b < 4; b++)
            if (be[b]) mdl[a[5]][a[4:2]][8*b +: 8] = d[8*b +: 8];
    endtask

    task automatic do_flush(input logic [31:0] a);
        @(negedge clk);
        fl_valid = 1'b1; fl_addr = a;
        #1;
        while (!fl_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        fl_valid = 1'b0;
    endtask

    // Drains one burst; stall bit k drops bw_ready on cycle k (mod 8).
    task automatic collect(input logic [31:0] line_a, input logic [7:0] stall, input string tag);
        int n = 0;
        int cyc = 0;
        bit hold = 0;
        logic [31:0] pa, pd;
        logic [31:0] base = line_a & 32'hFFFF_FFE0;
        int q = int'(line_a[5]);
        while (n < 8 && cyc < 200) begin
            @(negedge clk);
            bw_ready = !stall[cyc % 8];
            #1;
            if (cyc == 0) chk(q_busy == 2'(1 << q), {"R8 busy ", tag}, 32'(q_busy), 32'(1 << q));
            if (hold) begin
                chk(bw_addr === pa, {"R6 addr hold ", tag}, bw_addr, pa);
                chk(bw_data === pd, {"R6 data hold ", tag}, bw_data, pd);
            end
            if (bw_valid && bw_ready) begin
                chk(bw_addr === base + 32'(4 * n), {"R3 addr ", tag}, bw_addr, base + 32'(4 * n));
                chk(bw_data === mdl[q][n], {"R1 R3 data ", tag}, bw_data, mdl[q][n]);
                chk(bw_last === (n == 7), {"R2 last ", tag}, 32'(bw_last), 32'(n == 7));
                n++;
            end
            hold = bw_valid && !bw_ready;
            pa = bw_addr; pd = bw_data;
            cyc++;
        end
        chk(n == 8, {"R2 beat count ", tag}, 32'(n), 32'd8);
        @(negedge clk);
        bw_ready = 1'b0;
        #1;
        chk(flush_done === 1'b1, {"R8 done ", tag}, 32'(flush_done), 32'd1);
        chk(bw_valid === 1'b0, {"R2 no extra beat ", tag}, 32'(bw_valid), 32'd0);
        chk(q_busy === 2'b00, {"R8 busy clear ", tag}, 32'(q_busy), 32'd0);
        @(negedge clk); #1;
        chk(flush_done === 1'b0, {"R8 done one cycle ", tag}, 32'(flush_done), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(bw_valid === 1'b0, "R9 bw_valid", 32'(bw_valid), 32'd0);
        chk(q_busy === 2'b00, "R9 q_busy", 32'(q_busy), 32'd0);
        chk(flush_done === 1'b0, "R9 flush_done", 32'(flush_done), 32'd0);
        chk(st_ready === 1'b1, "R9 st_ready", 32'(st_ready), 32'd1);
        chk(fl_ready === 1'b1, "R9 fl_ready", 32'(fl_ready), 32'd1);
    endtask

    task automatic t_basic();
        bit seen = 0;
        for (int i = 0; i < 8; i++) do_store(32'h1000_0000 + 32'(4 * i), 32'hA0A0_0000 + 32'(i), 4'hF);
        for (int i = 0; i < 8; i++) do_store(32'h2000_0020 + 32'(4 * i), 32'hB1B1_0000 + 32'(i * 3), 4'hF);
        for (int i = 0; i < 30; i++) begin @(negedge clk); #1; if (bw_valid) seen = 1; end
        chk(!seen, "R4 no write without flush", 32'(seen), 32'd0);
        do_flush(32'h1000_0013);
        collect(32'h1000_0000, 8'h00, "q0 basic");
    endtask

    task automatic t_stall();
        do_flush(32'h2000_003C);
        collect(32'h2000_0020, 8'b1010_0110, "q1 backpressure");
    endtask

    task automatic t_partial();
        do_store(32'h0000_000C, 32'h1122_3344, 4'b0101);
        do_store(32'h0000_001C, 32'h5566_7788, 4'b1000);
        do_flush(32'h3000_0040);
        collect(32'h3000_0040, 8'h00, "R1 partial bytes");
    endtask

    task automatic t_conflict();
        logic [31:0] a0;
        do_flush(32'h2000_0020);
        @(negedge clk);
        fl_valid = 1'b1; fl_addr = 32'h1000_0000;
        st_valid = 1'b1; st_addr = 32'h2000_0020; st_data = 32'hDEAD_BEEF; st_be = 4'hF;
        #1;
        a0 = bw_addr;
        chk(fl_ready === 1'b0, "R7 flush stalled", 32'(fl_ready), 32'd0);
        chk(st_ready === 1'b0, "R5 store stalled", 32'(st_ready), 32'd0);
        chk(q_busy === 2'b10, "R8 busy q1", 32'(q_busy), 32'h2);
        @(negedge clk); #1;
        chk(st_ready === 1'b0, "R5 store still stalled", 32'(st_ready), 32'd0);
        chk(bw_addr === a0, "R6 addr held", bw_addr, a0);
        st_addr = 32'h1000_0008; st_data = 32'hCAFE_F00D;
        #1;
        chk(st_ready === 1'b1, "R5 other queue open", 32'(st_ready), 32'd1);
        @(posedge clk); #1;
        st_valid = 1'b0; fl_valid = 1'b0;
        mdl[0][2] = 32'hCAFE_F00D;
        collect(32'h2000_0020, 8'h00, "R5 stalled store absent");
        do_flush(32'h1000_0000);
        collect(32'h1000_0000, 8'h00, "R5 other queue store");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        st_valid = 1'b1; st_addr = 32'h0000_0014; st_data = 32'h0BAD_CAFE; st_be = 4'hF;
        fl_valid = 1'b1; fl_addr = 32'h4000_0000;
        #1;
        chk(st_ready === 1'b1 && fl_ready === 1'b1, "R7 both accepted", 32'({st_ready, fl_ready}), 32'h3);
        @(posedge clk); #1;
        st_valid = 1'b0; fl_valid = 1'b0;
        mdl[0][5] = 32'h0BAD_CAFE;
        collect(32'h4000_0000, 8'h00, "R7 same-cycle store");
    endtask

    task automatic t_reflush();
        do_flush(32'h2000_0020);
        collect(32'h2000_0020, 8'b0000_0001, "R10 repeat flush");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_stall();
        t_partial();
        t_conflict();
        t_same_cycle();
        t_reflush();
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", 20000);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule